// File: doc/BRIEF.md
# Hamming Seven-Four Single-Error Codec

The block protects four-bit data with three check bits, giving a seven-bit code with minimum distance 3 and sixteen legal words. It has two independent halves. The encoder turns a data nibble into a codeword. The decoder takes a received seven-bit word and works out a three-bit syndrome. When the syndrome is zero, the word is a legal codeword. When it is not zero, an error is present.

A per-word mode input sets what the decoder does with a nonzero syndrome:

- **Repair mode.** The decoder trusts that at most one bit is wrong. Because d ≥ 2C + 1 with d = 3, the code can fix exactly one error. The decoder inverts the bit whose position the syndrome names, then extracts the data.
- **Detect-only mode.** The decoder never changes the word and only raises the error flag. In this mode every one-bit and two-bit error is caught. Three or more flipped bits can land on another legal word and pass unseen.

Both halves register their results once. Each result appears one clock after its input strobe, together with a single-cycle output strobe. The codeword width follows from a parity-width parameter, and the default is three check bits.

Top module: `ham_codec`

## Requirements
- R1: Codeword positions are numbered 1 to 7, with position p held in enc_word_o[p-1]. Check bits sit at positions 1, 2 and 4. Data bits d0, d1, d2 and d3 sit at positions 3, 5, 6 and 7. Check bit 2^j is chosen so that every position whose index has bit j set XORs to zero. Data 4'hB therefore encodes to 7'h55.
- R2: Syndrome bit j is the XOR of the received bits at all positions whose index has bit j set. For a legal codeword it is zero: dec_error_o and dec_fixed_o are 0, and dec_data_o holds the bits at positions 7, 6, 5 and 3 (MSB first).
- R3: With dec_fix_en_i = 1 and a nonzero syndrome, the decoder inverts the bit at position dec_syndrome_o before extracting data, and raises dec_error_o and dec_fixed_o. For any single flipped bit, the syndrome equals its position and the data is the original data.
- R4: With dec_fix_en_i = 0, the data is taken from the received word unchanged, dec_fixed_o is 0, and dec_error_o is 1 exactly when the syndrome is nonzero.
- R5: Any two flipped bits in a codeword give a nonzero syndrome (for example 7'h04 gives syndrome 3). In detect-only mode they are flagged as an error. In repair mode the wrong bit is inverted and dec_fixed_o is still raised.
- R6: Three flipped bits that turn a codeword into another legal word report a zero syndrome and no error. For example, 7'h00 with positions 1, 2 and 3 flipped reads as data 1.
- R7: Each output strobe is high in exactly the cycle after its input strobe. Result outputs keep their values while no input strobe arrives.
- R8: While rst_n is low, both output strobes and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 4 | Data nibble to encode |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_word_o | output | 7 | Registered codeword |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_word_i | input | 7 | Received word |
| dec_fix_en_i | input | 1 | 1 = repair single errors, 0 = detect only |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | 4 | Extracted (possibly repaired) data |
| dec_syndrome_o | output | 3 | Syndrome of the received word |
| dec_error_o | output | 1 | Nonzero syndrome seen |
| dec_fixed_o | output | 1 | A bit was inverted |

## Verification
A wrong check-bit mask or a mis-placed data bit shows at the ports on the strobe cycle of the first affected nibble, as a wrong codeword or wrong extracted data. The bench therefore drives all sixteen nibbles and every single-bit flip in both modes. A flip index that is off by one shows as a syndrome that does not match the flipped position, or as data that comes back unrepaired, in that same cycle. A missing hold on the result registers shows one cycle after any idle cycle.

// File: rtl/ham_pkg.sv
package ham_pkg;

   localparam int MAX_P = 6;
   localparam int MAX_W = 63;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // 1-based codeword position of data bit k (k-th non-power-of-two index)
   function automatic int data_pos(input int k);
      int seen;
      int res;
      seen = 0;
      res  = 0;
      for (int p = 1; p <= MAX_W; p++) begin
         if (!is_pow2(p)) begin
            if (seen == k && res == 0) res = p;
            seen++;
         end
      end
      return res;
   endfunction

   // positions whose index has bit j set
   function automatic logic [MAX_W-1:0] cover_mask(input int j);
      logic [MAX_W-1:0] m;
      for (int p = 1; p <= MAX_W; p++) m[p-1] = ((p >> j) & 1) == 1;
      return m;
   endfunction

   function automatic logic [MAX_P-1:0] calc_syn(input logic [MAX_W-1:0] w);
      logic [MAX_P-1:0] s;
      for (int j = 0; j < MAX_P; j++) s[j] = ^(w & cover_mask(j));
      return s;
   endfunction

endpackage

// File: rtl/ham_encoder.sv
module ham_encoder #(
   parameter int PARITY_W = 3,
   localparam int CODE_W = (1 << PARITY_W) - 1,
   localparam int DATA_W = CODE_W - PARITY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] word_o
);

   logic [CODE_W-1:0] dat_only;
   logic [CODE_W-1:0] word_c;

   for (genvar k = 0; k < DATA_W; k++) begin : g_place
      localparam int POS = ham_pkg::data_pos(k);
      assign dat_only[POS-1] = data_i[k];
      assign word_c[POS-1]   = data_i[k];
   end

   for (genvar j = 0; j < PARITY_W; j++) begin : g_chk
      localparam int CPOS = 1 << j;
      localparam logic [ham_pkg::MAX_W-1:0] MASK = ham_pkg::cover_mask(j);
      assign dat_only[CPOS-1] = 1'b0;
      assign word_c[CPOS-1]   = ^(dat_only & MASK[CODE_W-1:0]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         word_o  <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) word_o <= word_c;
      end
   end

   p_enc_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (ham_pkg::calc_syn(ham_pkg::MAX_W'(word_o)) == '0));

   p_enc_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);

   p_enc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(word_o) && !valid_o));

endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome #(
   parameter int PARITY_W = 3,
   localparam int CODE_W = (1 << PARITY_W) - 1
) (
   input  logic [CODE_W-1:0]   word_i,
   output logic [PARITY_W-1:0] syn_o
);

   for (genvar j = 0; j < PARITY_W; j++) begin : g_syn
      localparam logic [ham_pkg::MAX_W-1:0] MASK = ham_pkg::cover_mask(j);
      assign syn_o[j] = ^(word_i & MASK[CODE_W-1:0]);
   end

endmodule

// File: rtl/ham_decoder.sv
module ham_decoder #(
   parameter int PARITY_W = 3,
   localparam int CODE_W = (1 << PARITY_W) - 1,
   localparam int DATA_W = CODE_W - PARITY_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   input  logic [CODE_W-1:0]   word_i,
   input  logic                fix_en_i,
   output logic                valid_o,
   output logic [DATA_W-1:0]   data_o,
   output logic [PARITY_W-1:0] syn_o,
   output logic                err_o,
   output logic                fixed_o
);

   logic [PARITY_W-1:0] syn_c;
   logic [CODE_W:0]     one_hot;
   logic [CODE_W-1:0]   flip;
   logic [CODE_W-1:0]   fixed_word;
   logic [DATA_W-1:0]   data_c;
   logic                nz;

   ham_syndrome #(.PARITY_W(PARITY_W)) u_syn (
      .word_i (word_i),
      .syn_o  (syn_c)
   );

   // bit 0 of one_hot absorbs the zero syndrome
   assign one_hot    = (CODE_W + 1)'(1) << syn_c;
   assign flip       = fix_en_i ? one_hot[CODE_W:1] : '0;
   assign fixed_word = word_i ^ flip;
   assign nz         = |syn_c;

   for (genvar k = 0; k < DATA_W; k++) begin : g_pick
      localparam int POS = ham_pkg::data_pos(k);
      assign data_c[k] = fixed_word[POS-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         syn_o   <= '0;
         err_o   <= 1'b0;
         fixed_o <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            data_o  <= data_c;
            syn_o   <= syn_c;
            err_o   <= nz;
            fixed_o <= nz && fix_en_i;
         end
      end
   end

   p_fix_needs_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fixed_o |-> err_o);

   p_detect_no_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !fix_en_i) |=> !fixed_o);

   p_clean_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && syn_o == '0) |-> (!err_o && !fixed_o));

   p_dec_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);

   p_dec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(data_o) && $stable(syn_o) && !valid_o));

endmodule

// File: rtl/ham_codec.sv
module ham_codec #(
   parameter int PARITY_W = 3,
   localparam int CODE_W = (1 << PARITY_W) - 1,
   localparam int DATA_W = CODE_W - PARITY_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enc_valid_i,
   input  logic [DATA_W-1:0]   enc_data_i,
   output logic                enc_valid_o,
   output logic [CODE_W-1:0]   enc_word_o,
   input  logic                dec_valid_i,
   input  logic [CODE_W-1:0]   dec_word_i,
   input  logic                dec_fix_en_i,
   output logic                dec_valid_o,
   output logic [DATA_W-1:0]   dec_data_o,
   output logic [PARITY_W-1:0] dec_syndrome_o,
   output logic                dec_error_o,
   output logic                dec_fixed_o
);

   if (PARITY_W < 2 || PARITY_W > ham_pkg::MAX_P) begin : g_bad_width
      $error("ham_codec: PARITY_W must lie in 2..%0d", ham_pkg::MAX_P);
   end

   ham_encoder #(.PARITY_W(PARITY_W)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (enc_valid_i),
      .data_i  (enc_data_i),
      .valid_o (enc_valid_o),
      .word_o  (enc_word_o)
   );

   ham_decoder #(.PARITY_W(PARITY_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (dec_valid_i),
      .word_i   (dec_word_i),
      .fix_en_i (dec_fix_en_i),
      .valid_o  (dec_valid_o),
      .data_o   (dec_data_o),
      .syn_o    (dec_syndrome_o),
      .err_o    (dec_error_o),
      .fixed_o  (dec_fixed_o)
   );

   p_reset_quiet_r8: assert property (@(posedge clk)
      !rst_n |=> (!enc_valid_o && !dec_valid_o && dec_data_o == '0 && enc_word_o == '0));

endmodule

// File: tb/ham_codec_bench.sv
`timescale 1ns/1ps
module ham_codec_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enc_valid_i = 1'b0;
   logic [3:0] enc_data_i = '0;
   logic       enc_valid_o;
   logic [6:0] enc_word_o;
   logic       dec_valid_i = 1'b0;
   logic [6:0] dec_word_i = '0;
   logic       dec_fix_en_i = 1'b0;
   logic       dec_valid_o;
   logic [3:0] dec_data_o;
   logic [2:0] dec_syndrome_o;
   logic       dec_error_o;
   logic       dec_fixed_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ham_codec u_ham_codec (.*);

   // {word, fix_en, data, syndrome, error, fixed}
   localparam logic [16:0] VEC [9] = '{
      {7'h55, 1'b1, 4'hB, 3'd0, 1'b0, 1'b0},   // R2 legal word
      {7'h45, 1'b1, 4'hB, 3'd5, 1'b1, 1'b1},   // R3 pos 5 flipped
      {7'h45, 1'b0, 4'h9, 3'd5, 1'b1, 1'b0},   // R4 same, detect only
      {7'h7E, 1'b1, 4'hF, 3'd1, 1'b1, 1'b1},   // R3 check bit flipped
      {7'h3F, 1'b1, 4'hF, 3'd7, 1'b1, 1'b1},   // R3 last position
      {7'h04, 1'b0, 4'h1, 3'd3, 1'b1, 1'b0},   // R5 double error detected
      {7'h04, 1'b1, 4'h0, 3'd3, 1'b1, 1'b1},   // R5 double error miscorrected
      {7'h00, 1'b0, 4'h0, 3'd0, 1'b0, 1'b0},   // R2 zero word
      {7'h07, 1'b0, 4'h1, 3'd0, 1'b0, 1'b0}    // R6 triple error unseen
   };

   function automatic string vec_tag(input int i);
      case (i)
         0, 7:    return "R2";
         1, 3, 4: return "R3";
         2:       return "R4";
         5, 6:    return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic logic [6:0] enc_ref(input logic [3:0] d);
      logic p1, p2, p4;
      p1 = d[0] ^ d[1] ^ d[3];
      p2 = d[0] ^ d[2] ^ d[3];
      p4 = d[1] ^ d[2] ^ d[3];
      return {d[3], d[2], d[1], p4, d[0], p2, p1};
   endfunction

   function automatic logic [3:0] pick_ref(input logic [6:0] w);
      return {w[6], w[5], w[4], w[2]};
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic ev, input logic [3:0] ed,
                        input logic dv, input logic [6:0] dw, input logic fx);
      @(negedge clk);
      enc_valid_i  = ev;
      enc_data_i   = ed;
      dec_valid_i  = dv;
      dec_word_i   = dw;
      dec_fix_en_i = fx;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      enc_valid_i = 1'b0;
      dec_valid_i = 1'b0;
   endtask

   task automatic check_dec(input string tag, input logic [3:0] d, input logic [2:0] s,
                            input logic e, input logic f);
      check({tag, " valid"}, int'(dec_valid_o), 1);
      check({tag, " data"}, int'(dec_data_o), int'(d));
      check({tag, " syndrome"}, int'(dec_syndrome_o), int'(s));
      check({tag, " error"}, int'(dec_error_o), int'(e));
      check({tag, " fixed"}, int'(dec_fixed_o), int'(f));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [6:0] w;
      logic [3:0] held;
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      check("R8 enc valid", int'(enc_valid_o), 0);
      check("R8 dec valid", int'(dec_valid_o), 0);
      check("R8 enc word", int'(enc_word_o), 0);
      check("R8 dec data", int'(dec_data_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 known example
      drive(1'b1, 4'hB, 1'b0, 7'h00, 1'b0);
      check("R1 enc valid", int'(enc_valid_o), 1);
      check("R1 enc B", int'(enc_word_o), 'h55);
      idle();

      // vector table
      for (int i = 0; i < 9; i++) begin
         drive(1'b0, 4'h0, 1'b1, VEC[i][16:10], VEC[i][9]);
         check_dec(vec_tag(i), VEC[i][8:5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
         idle();
      end

      // exhaustive data with every single flip, both modes
      for (int d = 0; d < 16; d++) begin
         drive(1'b1, 4'(d), 1'b1, enc_ref(4'(d)), 1'b1);
         check("R1 encode", int'(enc_word_o), int'(enc_ref(4'(d))));
         check_dec("R2 clean", 4'(d), 3'd0, 1'b0, 1'b0);
         for (int p = 1; p <= 7; p++) begin
            w = enc_ref(4'(d)) ^ (7'(1) << (p - 1));
            drive(1'b0, 4'h0, 1'b1, w, 1'b1);
            check_dec("R3 repair", 4'(d), 3'(p), 1'b1, 1'b1);
            drive(1'b0, 4'h0, 1'b1, w, 1'b0);
            check_dec("R4 detect", pick_ref(w), 3'(p), 1'b1, 1'b0);
         end
         idle();
      end

      // R7 strobe lasts one cycle and results hold while idle
      drive(1'b1, 4'h6, 1'b1, 7'h7E, 1'b1);
      held = dec_data_o;
      idle();
      @(posedge clk);
      #1;
      check("R7 enc strobe drop", int'(enc_valid_o), 0);
      check("R7 dec strobe drop", int'(dec_valid_o), 0);
      @(negedge clk);
      dec_word_i = 7'h00;
      enc_data_i = 4'h1;
      repeat (3) @(posedge clk);
      #1;
      check("R7 data held", int'(dec_data_o), int'(held));
      check("R7 word held", int'(enc_word_o), int'(enc_ref(4'h6)));
      check("R7 still idle", int'(dec_valid_o), 0);

      // R8 reset mid-stream
      drive(1'b1, 4'hF, 1'b1, 7'h3F, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R8 reset dec valid", int'(dec_valid_o), 0);
      check("R8 reset dec data", int'(dec_data_o), 0);
      check("R8 reset enc word", int'(enc_word_o), 0);
      check("R8 reset err", int'(dec_error_o), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule